// File: doc/BRIEF.md
# Shared Serial EEPROM Access Arbiter

This block lets four agents share one serial configuration EEPROM: a hardware loader that fetches words after reset, the drivers of two network ports, and a management firmware agent. Any of them can post a word-level request (read or write). The block then runs the serial transaction itself and hands back the result with a one-cycle completion pulse. Pending requests are served in rotating order, so no agent waits forever.

The two drivers and the firmware can also take an exclusive lock and drive the EEPROM chip-select, serial clock and data lines themselves. While the lock is held, the owner's three pin inputs pass straight to the device and every other request waits. A holder that stops moving its pins loses the lock once a configurable number of clock cycles has passed. It can read its grant bit at any time to learn whether it still owns the device. A holder that was revoked must withdraw its lock request before it can be granted again.

Top module: `eeprom_share_arb`

## Requirements
- R1: After reset no lock grant is set, no completion pulse is raised and the EEPROM chip-select is low.
- R2: A word request produces a frame with chip-select high, made of a start bit 1, an op bit (1 = write, 0 = read), the address MSB first, then DW data bits MSB first. Each bit is presented with the serial clock low for one cycle and then high for one cycle, and read data is sampled while the clock is high. Completion is a single-cycle `par_done` pulse for the requester, with read data on `par_rdata` in that cycle.
- R3: Among pending requests, service rotates: the next client served is the first pending one after the client last served, in index order with wrap-around.
- R4: Client 0 (the hardware loader) can never obtain the lock; its `bb_req` has no effect on grants or pins.
- R5: While a lock is held, at most one grant bit is set and no word transaction starts. The EEPROM pins follow only the owner's pin inputs; other clients' pin inputs are ignored.
- R6: A lock request that arrives during a word transaction is granted only after that transaction completes, two cycles after its completion pulse.
- R7: If the owner's chip-select, clock and data inputs all stay unchanged for TIMEOUT_CYC consecutive cycles, the lock is revoked and the owner's grant bit clears.
- R8: Any change on one of the owner's three pin inputs restarts the inactivity count.
- R9: A revoked client that keeps `bb_req` high is not granted again until it has dropped `bb_req` for at least one cycle.
- R10: Dropping `bb_req` releases the lock at the next clock edge. With no lock and no transaction, chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_req | input | N_CLI | Word request per client, held until its done pulse |
| par_we | input | N_CLI | 1 = write, 0 = read, per client |
| par_addr | input | N_CLI*AW | Word address per client, client i at bits [i*AW +: AW] |
| par_wdata | input | N_CLI*DW | Write data per client, client i at bits [i*DW +: DW] |
| par_done | output | N_CLI | One-cycle completion pulse per client |
| par_rdata | output | DW | Read data, valid with par_done |
| bb_req | input | N_CLI | Lock request per client |
| bb_cs | input | N_CLI | Chip-select each client drives while it owns the lock |
| bb_sk | input | N_CLI | Serial clock each client drives while it owns the lock |
| bb_di | input | N_CLI | Serial data to the device each client drives while it owns the lock |
| bb_gnt | output | N_CLI | Lock ownership status per client |
| bb_sdo | output | 1 | Device data out, passed to the lock owner |
| ee_cs | output | 1 | EEPROM chip-select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM serial data in |
| ee_do | input | 1 | EEPROM serial data out |

## Verification
A wrong owner index or a stale lock state shows on the pins at once: `ee_cs` no longer matches the granted client's `bb_cs`, in the same cycle. A bad rotation pointer shows up in the next service order among four simultaneous requests. An inactivity counter that reloads wrongly shifts the revocation edge by whole cycles, so the grant bit is probed just before and just after the expected cycle. A lost revoke flag re-grants a client that still holds its request, and this is visible within the first idle cycle after revocation.

// File: rtl/eesh_pkg.sv
package eesh_pkg;
   typedef enum logic [1:0] {ARB_IDLE, ARB_SERIAL, ARB_LOCKED} arb_state_t;
   typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH, SH_DONE} shift_state_t;
endpackage

// File: rtl/eesh_rr_pick.sv
module eesh_rr_pick #(
   parameter int N = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req,
   input  logic                 take,
   output logic                 any,
   output logic [$clog2(N)-1:0] pick
);
   localparam int IW = $clog2(N);

   generate
      if (N < 2) begin : g_bad_n
         $error("eesh_rr_pick: N must be at least 2");
      end
   endgenerate

   logic [IW-1:0] ptr;

   always_comb begin
      int j;
      any  = 1'b0;
      pick = ptr;
      for (int k = 0; k < N; k++) begin
         j = (int'(ptr) + k) % N;
         if (!any && req[j]) begin
            any  = 1'b1;
            pick = IW'(j);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (take && any) begin
         ptr <= (int'(pick) == N-1) ? '0 : pick + 1'b1;
      end
   end

   AST_PICK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (take && any) |-> req[pick]); // R3
endmodule

// File: rtl/eesh_serial_engine.sv
module eesh_serial_engine
   import eesh_pkg::*;
#(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          sdo_i,
   output logic          cs_o,
   output logic          sk_o,
   output logic          di_o,
   output logic          busy_o,
   output logic          done_o,
   output logic [DW-1:0] rdata_o
);
   localparam int FW  = 2 + AW + DW;
   localparam int IW  = $clog2(FW + 1);
   localparam int HDR = 2 + AW;

   generate
      if (AW < 1) begin : g_bad_aw
         $error("eesh_serial_engine: AW must be at least 1");
      end
      if (DW < 2) begin : g_bad_dw
         $error("eesh_serial_engine: DW must be at least 2");
      end
   endgenerate

   shift_state_t  st;
   logic [FW-1:0] frame;
   logic [IW-1:0] idx;
   logic          wr_q;
   logic [DW-1:0] rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SH_IDLE;
         frame <= '0;
         idx   <= '0;
         wr_q  <= 1'b0;
         rx    <= '0;
      end else begin
         unique case (st)
            SH_IDLE: begin
               if (start_i) begin
                  frame <= {1'b1, we_i, addr_i, (we_i ? wdata_i : {DW{1'b0}})};
                  wr_q  <= we_i;
                  idx   <= '0;
                  rx    <= '0;
                  st    <= SH_LOW;
               end
            end
            SH_LOW: st <= SH_HIGH;
            SH_HIGH: begin
               if (!wr_q && (idx >= IW'(HDR))) begin
                  rx <= {rx[DW-2:0], sdo_i};
               end
               frame <= {frame[FW-2:0], 1'b0};
               if (idx == IW'(FW-1)) begin
                  st <= SH_DONE;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= SH_LOW;
               end
            end
            SH_DONE: st <= SH_IDLE;
            default: st <= SH_IDLE;
         endcase
      end
   end

   assign cs_o    = (st == SH_LOW) || (st == SH_HIGH);
   assign sk_o    = (st == SH_HIGH);
   assign di_o    = cs_o & frame[FW-1];
   assign busy_o  = (st != SH_IDLE);
   assign done_o  = (st == SH_DONE);
   assign rdata_o = rx;

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (st == SH_IDLE)); // R6
   AST_DONE_AFTER_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(sk_o)); // R2
endmodule

// File: rtl/eesh_lock_watchdog.sv
module eesh_lock_watchdog #(
   parameter int LIMIT = 200_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lock_i,
   input  logic [2:0] pins_i,
   output logic       expire_o
);
   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("eesh_lock_watchdog: LIMIT must be at least 2");
      end
   endgenerate

   logic          lock_q;
   logic [2:0]    prev;
   logic [CW-1:0] cnt;
   logic          act;

   assign act      = lock_i && lock_q && (pins_i != prev);
   assign expire_o = lock_i && !act && (cnt == CW'(LIMIT-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         prev   <= '0;
         cnt    <= '0;
      end else begin
         lock_q <= lock_i;
         prev   <= pins_i;
         if (!lock_i || act) begin
            cnt <= '0;
         end else if (cnt != CW'(LIMIT-1)) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_EXPIRE_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> !lock_i); // R7
   AST_ACTIVITY_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (act && lock_i) |=> (!expire_o)); // R8
endmodule

// File: rtl/eeprom_share_arb.sv
module eeprom_share_arb
   import eesh_pkg::*;
#(
   parameter int               N_CLI       = 4,
   parameter int               AW          = 6,
   parameter int               DW          = 16,
   parameter int               TIMEOUT_CYC = 200_000_000,
   parameter logic [N_CLI-1:0] BB_ALLOW    = 4'b1110
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_CLI-1:0]    par_req,
   input  logic [N_CLI-1:0]    par_we,
   input  logic [N_CLI*AW-1:0] par_addr,
   input  logic [N_CLI*DW-1:0] par_wdata,
   output logic [N_CLI-1:0]    par_done,
   output logic [DW-1:0]       par_rdata,
   input  logic [N_CLI-1:0]    bb_req,
   input  logic [N_CLI-1:0]    bb_cs,
   input  logic [N_CLI-1:0]    bb_sk,
   input  logic [N_CLI-1:0]    bb_di,
   output logic [N_CLI-1:0]    bb_gnt,
   output logic                bb_sdo,
   output logic                ee_cs,
   output logic                ee_sk,
   output logic                ee_di,
   input  logic                ee_do
);
   localparam int IW = $clog2(N_CLI);

   generate
      if (N_CLI < 2) begin : g_bad_ncli
         $error("eeprom_share_arb: N_CLI must be at least 2");
      end
      if (BB_ALLOW[0]) begin : g_bad_allow
         $error("eeprom_share_arb: client 0 may not take the lock");
      end
   endgenerate

   arb_state_t       st;
   logic [IW-1:0]    owner;
   logic [IW-1:0]    cur;
   logic [N_CLI-1:0] revoked;
   logic [N_CLI-1:0] bb_elig;
   logic [N_CLI-1:0] elig;
   logic             take;
   logic             any;
   logic [IW-1:0]    pick;
   logic             want_lock;
   logic             start;
   logic             locked;
   logic [AW-1:0]    sel_addr;
   logic [DW-1:0]    sel_wdata;
   logic             eng_cs, eng_sk, eng_di, eng_busy, eng_done;
   logic [DW-1:0]    eng_rdata;
   logic [2:0]       own_pins;
   logic             wd_expire;

   assign bb_elig   = bb_req & BB_ALLOW & ~revoked;
   assign elig      = par_req | bb_elig;
   assign take      = (st == ARB_IDLE) && !eng_busy;
   assign want_lock = bb_elig[pick];
   assign start     = take && any && !want_lock;
   assign locked    = (st == ARB_LOCKED);
   assign sel_addr  = par_addr[int'(pick)*AW +: AW];
   assign sel_wdata = par_wdata[int'(pick)*DW +: DW];
   assign own_pins  = {bb_cs[owner], bb_sk[owner], bb_di[owner]};

   eesh_rr_pick #(.N(N_CLI)) u_pick (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (elig),
      .take (take),
      .any  (any),
      .pick (pick)
   );

   eesh_serial_engine #(.AW(AW), .DW(DW)) u_engine (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start),
      .we_i   (par_we[pick]),
      .addr_i (sel_addr),
      .wdata_i(sel_wdata),
      .sdo_i  (ee_do),
      .cs_o   (eng_cs),
      .sk_o   (eng_sk),
      .di_o   (eng_di),
      .busy_o (eng_busy),
      .done_o (eng_done),
      .rdata_o(eng_rdata)
   );

   eesh_lock_watchdog #(.LIMIT(TIMEOUT_CYC)) u_watchdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock_i  (locked),
      .pins_i  (own_pins),
      .expire_o(wd_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ARB_IDLE;
         owner   <= '0;
         cur     <= '0;
         revoked <= '0;
      end else begin
         for (int i = 0; i < N_CLI; i++) begin
            if (!bb_req[i]) revoked[i] <= 1'b0;
         end
         unique case (st)
            ARB_IDLE: begin
               if (take && any) begin
                  if (want_lock) begin
                     owner <= pick;
                     st    <= ARB_LOCKED;
                  end else begin
                     cur <= pick;
                     st  <= ARB_SERIAL;
                  end
               end
            end
            ARB_SERIAL: begin
               if (eng_done) st <= ARB_IDLE;
            end
            ARB_LOCKED: begin
               if (!bb_req[owner] || wd_expire) st <= ARB_IDLE;
               if (wd_expire && bb_req[owner]) revoked[owner] <= 1'b1;
            end
            default: st <= ARB_IDLE;
         endcase
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < N_CLI; gi++) begin : g_client
         assign par_done[gi] = eng_done && (int'(cur) == gi);
         if (BB_ALLOW[gi]) begin : g_lockable
            assign bb_gnt[gi] = locked && (int'(owner) == gi);
         end else begin : g_fixed
            assign bb_gnt[gi] = 1'b0;
         end
      end
   endgenerate

   assign ee_cs     = locked ? own_pins[2] : eng_cs;
   assign ee_sk     = locked ? own_pins[1] : eng_sk;
   assign ee_di     = locked ? own_pins[0] : eng_di;
   assign bb_sdo    = locked & ee_do;
   assign par_rdata = eng_rdata;

   AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bb_gnt)); // R5
   AST_LOADER_NEVER_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      !bb_gnt[0]); // R4
   AST_NO_SERIAL_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (|bb_gnt) |-> !eng_busy); // R5
   AST_PINS_FOLLOW_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      (|bb_gnt) |-> (ee_cs == |(bb_gnt & bb_cs))); // R5
   AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(par_done)); // R2
   AST_RELEASE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (|(bb_gnt & ~bb_req)) |=> (bb_gnt == '0)); // R10
   AST_IDLE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ((bb_gnt == '0) && !eng_busy) |-> !ee_cs); // R10
endmodule

// File: tb/eeprom_share_arb_test.sv
module eeprom_share_arb_test;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int AW = 6;
   localparam int DW = 16;
   localparam int TO = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    par_req = '0, par_we = '0;
   logic [N*AW-1:0] par_addr = '0;
   logic [N*DW-1:0] par_wdata = '0;
   logic [N-1:0]    par_done;
   logic [DW-1:0]   par_rdata;
   logic [N-1:0]    bb_req = '0, bb_cs = '0, bb_sk = '0, bb_di = '0;
   logic [N-1:0]    bb_gnt;
   logic            bb_sdo;
   logic            ee_cs, ee_sk, ee_di;
   logic            ee_do = 1'b0;

   int checks = 0;
   int failures = 0;
   int done_cnt [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   eeprom_share_arb #(.N_CLI(N), .AW(AW), .DW(DW), .TIMEOUT_CYC(TO), .BB_ALLOW(4'b1110)) uut (
      .clk(clk), .rst_n(rst_n),
      .par_req(par_req), .par_we(par_we), .par_addr(par_addr), .par_wdata(par_wdata),
      .par_done(par_done), .par_rdata(par_rdata),
      .bb_req(bb_req), .bb_cs(bb_cs), .bb_sk(bb_sk), .bb_di(bb_di),
      .bb_gnt(bb_gnt), .bb_sdo(bb_sdo),
      .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
   );

   // Device responder: captures bits on rising serial clock, chip-select low clears it
   logic [DW-1:0] mem [64];
   int            rcnt = 0;
   logic [2+AW+DW-1:0] rsh = '0;
   logic [AW-1:0] raddr = '0;
   logic          rwe = 1'b0;

   initial begin
      for (int a = 0; a < 64; a++) mem[a] = 16'(16'h1200 + a * 37);
   end

   always @(posedge ee_sk or negedge ee_cs) begin
      if (!ee_cs) begin
         rcnt = 0;
      end else begin
         rsh  = {rsh[2+AW+DW-2:0], ee_di};
         rcnt = rcnt + 1;
         if (rcnt == 2 + AW) begin
            rwe   = rsh[AW];
            raddr = rsh[AW-1:0];
         end
         if (rcnt > 2 + AW && rcnt <= 2 + AW + DW && !rwe)
            ee_do = mem[raddr][DW-1-(rcnt-3-AW)];
         if (rcnt == 2 + AW + DW && rwe)
            mem[raddr] = rsh[DW-1:0];
      end
   end

   always @(negedge clk) begin
      for (int i = 0; i < N; i++) if (par_done[i]) done_cnt[i]++;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic par_op(input int c, input bit we, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] rd,
                         output bit seen, output bit one_cycle);
      par_we[c] = we;
      par_addr[c*AW +: AW] = a;
      par_wdata[c*DW +: DW] = d;
      par_req[c] = 1'b1;
      seen = 1'b0;
      rd = '0;
      for (int t = 0; t < 400; t++) begin
         @(negedge clk);
         if (par_done[c]) begin seen = 1'b1; break; end
      end
      rd = par_rdata;
      par_req[c] = 1'b0;
      @(negedge clk);
      one_cycle = (par_done[c] == 1'b0);
   endtask

   task automatic bb_write(input int c, input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [2+AW+DW-1:0] f;
      f = {1'b1, 1'b1, a, d};
      bb_cs[c] = 1'b1;
      for (int i = 2 + AW + DW - 1; i >= 0; i--) begin
         bb_sk[c] = 1'b0;
         bb_di[c] = f[i];
         repeat (2) @(negedge clk);
         bb_sk[c] = 1'b1;
         repeat (2) @(negedge clk);
      end
      bb_sk[c] = 1'b0;
      bb_cs[c] = 1'b0;
      bb_di[c] = 1'b0;
      @(negedge clk);
   endtask

   // {client[1:0], we, addr[5:0], wdata[15:0], expected[15:0]}
   localparam logic [40:0] VEC [8] = '{
      {2'd0, 1'b0, 6'd3,  16'h0000, 16'h126F},
      {2'd1, 1'b1, 6'd10, 16'hA55A, 16'h0000},
      {2'd2, 1'b0, 6'd10, 16'h0000, 16'hA55A},
      {2'd3, 1'b1, 6'd63, 16'hFFFF, 16'h0000},
      {2'd0, 1'b0, 6'd63, 16'h0000, 16'hFFFF},
      {2'd2, 1'b1, 6'd0,  16'h0001, 16'h0000},
      {2'd3, 1'b0, 6'd0,  16'h0000, 16'h0001},
      {2'd1, 1'b0, 6'd42, 16'h0000, 16'h1812}
   };

   initial begin
      repeat (400000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [DW-1:0] rd;
      bit seen, one;
      int order [4];
      int n;
      int base;
      for (int i = 0; i < N; i++) done_cnt[i] = 0;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(bb_gnt == '0, "R1", "grant in reset", 32'(bb_gnt), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(bb_gnt == '0, "R1", "grant after reset", 32'(bb_gnt), 0);
      check(ee_cs == 1'b0, "R1", "cs after reset", 32'(ee_cs), 0);
      check(par_done == '0, "R1", "done after reset", 32'(par_done), 0);

      // R2: table of word transactions
      foreach (VEC[v]) begin
         par_op(int'(VEC[v][40:39]), VEC[v][38], VEC[v][37:32], VEC[v][31:16], rd, seen, one);
         check(seen, "R2", "completion seen", 32'(seen), 1);
         check(one, "R2", "done lasts one cycle", 32'(one), 1);
         if (!VEC[v][38]) check(rd == VEC[v][15:0], "R2", "read data", 32'(rd), 32'(VEC[v][15:0]));
      end

      // R3: four simultaneous requests, last served was client 1 -> 2,3,0,1
      for (int c = 0; c < N; c++) begin
         par_we[c] = 1'b0;
         par_addr[c*AW +: AW] = AW'(c + 1);
      end
      par_req = 4'b1111;
      n = 0;
      for (int t = 0; t < 2000 && n < 4; t++) begin
         @(negedge clk);
         for (int c = 0; c < N; c++) if (par_done[c]) begin order[n] = c; n++; par_req[c] = 1'b0; end
      end
      check(n == 4 && order[0] == 2 && order[1] == 3 && order[2] == 0 && order[3] == 1, "R3",
            "rotation order 2301", 32'({order[0][3:0], order[1][3:0], order[2][3:0], order[3][3:0]}), 32'h2301);
      // R3: clients 0 and 2 pending after client 1 served -> 2 then 0
      par_req = 4'b0101;
      n = 0;
      for (int t = 0; t < 2000 && n < 2; t++) begin
         @(negedge clk);
         for (int c = 0; c < N; c++) if (par_done[c]) begin order[n] = c; n++; par_req[c] = 1'b0; end
      end
      check(n == 2 && order[0] == 2 && order[1] == 0, "R3", "rotation order 20",
            32'({order[0][3:0], order[1][3:0]}), 32'h20);

      // R4: loader lock request has no effect
      bb_req[0] = 1'b1;
      bb_cs[0] = 1'b1;
      repeat (20) @(negedge clk);
      check(bb_gnt == '0, "R4", "loader grant", 32'(bb_gnt), 0);
      check(ee_cs == 1'b0, "R4", "loader pins ignored", 32'(ee_cs), 0);
      bb_req[0] = 1'b0;
      bb_cs[0] = 1'b0;
      @(negedge clk);

      // R6: lock request during a word transaction waits for it
      par_we[0] = 1'b0;
      par_addr[0 +: AW] = 6'd5;
      par_req[0] = 1'b1;
      repeat (5) @(negedge clk);
      bb_req[3] = 1'b1;
      bb_cs[3] = 1'b1;
      bb_di[3] = 1'b1;
      repeat (3) @(negedge clk);
      check(bb_gnt[3] == 1'b0, "R6", "no grant mid transaction", 32'(bb_gnt), 0);
      for (int t = 0; t < 200; t++) begin
         if (par_done[0]) break;
         @(negedge clk);
      end
      par_req[0] = 1'b0;
      @(negedge clk);
      check(bb_gnt[3] == 1'b0, "R6", "grant one cycle after done", 32'(bb_gnt), 0);
      @(negedge clk);
      check(bb_gnt == 4'b1000, "R6", "grant two cycles after done", 32'(bb_gnt), 32'h8);

      // R5: exclusive ownership, foreign pins ignored, queued request held
      base = done_cnt[1];
      par_we[1] = 1'b1;
      par_addr[1*AW +: AW] = 6'd7;
      par_wdata[1*DW +: DW] = 16'h1234;
      par_req[1] = 1'b1;
      bb_cs[2] = 1'b1; bb_sk[2] = 1'b1; bb_di[2] = 1'b0;
      bb_sk[3] = 1'b0;
      repeat (10) @(negedge clk);
      check({ee_cs, ee_sk, ee_di} == 3'b101, "R5", "pins follow owner", 32'({ee_cs, ee_sk, ee_di}), 32'h5);
      bb_write(3, 6'd20, 16'hBEEF);
      check(bb_gnt == 4'b1000, "R8", "lock kept by activity", 32'(bb_gnt), 32'h8);
      check(done_cnt[1] == base, "R5", "no transaction under lock", 32'(done_cnt[1] - base), 0);
      bb_cs[2] = 1'b0; bb_sk[2] = 1'b0;
      bb_req[3] = 1'b0;
      @(negedge clk);
      check(bb_gnt == '0, "R10", "release on drop", 32'(bb_gnt), 0);
      for (int t = 0; t < 200; t++) begin
         @(negedge clk);
         if (par_done[1]) break;
      end
      par_req[1] = 1'b0;
      @(negedge clk);
      par_op(0, 1'b0, 6'd20, '0, rd, seen, one);
      check(rd == 16'hBEEF, "R5", "owner pins reached device", 32'(rd), 32'hBEEF);
      par_op(0, 1'b0, 6'd7, '0, rd, seen, one);
      check(rd == 16'h1234, "R5", "held request served after release", 32'(rd), 32'h1234);

      // R7: static owner pins -> revoke after TO cycles
      bb_cs[2] = 1'b1;
      bb_req[2] = 1'b1;
      for (int t = 0; t < 20; t++) begin
         @(negedge clk);
         if (bb_gnt[2]) break;
      end
      repeat (TO - 1) @(negedge clk);
      check(bb_gnt[2] == 1'b1, "R7", "still owned before limit", 32'(bb_gnt), 32'h4);
      @(negedge clk);
      check(bb_gnt == '0, "R7", "revoked at limit", 32'(bb_gnt), 0);
      check(ee_cs == 1'b0, "R10", "idle cs low after revoke", 32'(ee_cs), 0);
      // R9: held request is not re-granted
      repeat (30) @(negedge clk);
      check(bb_gnt == '0, "R9", "no regrant while held", 32'(bb_gnt), 0);
      bb_req[2] = 1'b0;
      repeat (2) @(negedge clk);
      bb_req[2] = 1'b1;
      for (int t = 0; t < 20; t++) begin
         @(negedge clk);
         if (bb_gnt[2]) break;
      end
      check(bb_gnt == 4'b0100, "R9", "regrant after drop", 32'(bb_gnt), 32'h4);

      // R8: a single pin change restarts the count
      repeat (50) @(negedge clk);
      bb_di[2] = 1'b1;
      repeat (62) @(negedge clk);
      check(bb_gnt == 4'b0100, "R8", "reloaded count keeps lock", 32'(bb_gnt), 32'h4);
      repeat (4) @(negedge clk);
      check(bb_gnt == '0, "R8", "revoked after reloaded limit", 32'(bb_gnt), 0);
      bb_req[2] = 1'b0;
      bb_cs[2] = 1'b0;
      bb_di[2] = 1'b0;
      repeat (3) @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule